// File: doc/BRIEF.md
# Branch Trace Recorder with Loop Folding

This block sits beside a processor core and keeps a short history of program-flow discontinuities. Every time the core takes a branch it presents the address it left from and the address it arrived at, together with a flag that marks zero-overhead hardware-loop iterations and the core's current interrupt level. Pairs that pass the recording rules go into a circular store of source/destination slots.

Software inspects the history through three word registers: a control word, an occupancy count and a data port. The data port yields the most recent pair first, one 32-bit half per read, and removes the pair once both halves have been taken. Tight loops would otherwise flush the store, so two folding modes can mark a repeat of the newest or second-newest pair in place instead of storing it again. When the store is full the block either discards its oldest pair or refuses the new one and signals an overflow exception to the core.

Top module: `branch_trace_buffer`

## Requirements
- R1: After reset the control word reads 0, the count reads 0, the data port reads 0 and `ovf_exc` is low.
- R2: A branch is stored only while control bit 0 (power) and control bit 1 (enable) are both 1; with either bit clear the count does not change.
- R3: A branch presented with `tr_hwloop` high is never stored.
- R4: Nothing is stored at interrupt level 1 (reset level); with control bit 2 (overflow-exception mode) set, nothing is stored at levels 0 to 3 either, and no exception is raised there.
- R5: A read of the data port (offset 0x100) returns 0 on an empty store and leaves the read phase unchanged; otherwise the first read returns the newest pair's destination and the next returns its source and removes that pair, so pairs come out newest first.
- R6: A read of offset 0x4 returns the number of stored pairs, never more than 16.
- R7: With control bit 2 clear, a branch arriving at a full store (16 pairs) evicts the oldest pair and is stored; the count stays 16.
- R8: With control bit 2 set, a branch at level 4 or above arriving at a full store is dropped and `ovf_exc` is high for exactly the one cycle following the branch's cycle.
- R9: With control bit 3 set and at least one pair stored, a branch whose source and destination equal the newest pair's (bit 0 ignored) is not stored; bit 0 of that pair's destination becomes 1.
- R10: With control bit 4 set and at least two pairs stored, a branch matching the second-newest pair (bit 0 ignored) is not stored; bit 0 of that pair's source becomes 1. When both folds match, only the newest-pair fold applies.
- R11: Offset 0x0 holds the control word: bits 4:0 are written and read back, other bits read 0; writes to offsets 0x4 and 0x100 change neither the control word, the count nor the read phase.
- R12: When a data-port read that removes a pair coincides with a branch, the removal happens first and the branch is judged against the reduced count, so a full store in exception mode accepts it without an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | A branch is presented this cycle |
| tr_src | input | 32 | Address the branch left from |
| tr_dst | input | 32 | Address the branch arrived at |
| tr_hwloop | input | 1 | Branch is a hardware-loop iteration |
| tr_level | input | 4 | Current interrupt level of the core |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| ovf_exc | output | 1 | One-cycle overflow exception request |

## Verification
The hardest situation to reach is a pair removal and a new branch landing in the same cycle on a full store in exception mode, since it needs sixteen stored pairs, the read phase already past the destination half, and the branch aligned to the popping read. The stimulus fills the store at a non-privileged level with exception mode on, forces one refused branch to show the pulse, reads one destination half, then drives the source-half read and a fresh branch in one cycle and follows with a count read and a newest-first drain. Folding is reached by storing identical pairs with folding off and then turning both folds on, so that the priority between them becomes visible in the drained halves.

// File: rtl/brt_pkg.sv
package brt_pkg;
   localparam int unsigned PC_W   = 32;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CTRL_W = 5;

   // Control word layout, bit 0 upward.
   typedef struct packed {
      logic fold2;
      logic fold1;
      logic ovx;
      logic en;
      logic pwr;
   } ctrl_t;

   typedef struct packed {
      logic [PC_W-1:0] src;
      logic [PC_W-1:0] dst;
   } pair_t;
endpackage

// File: rtl/brt_gate.sv
module brt_gate
   import brt_pkg::*;
#(
   parameter int unsigned LVL_W     = 4,
   parameter int unsigned RESET_LVL = 1,
   parameter int unsigned HIPRI_MAX = 3
) (
   input  logic             valid_i,
   input  logic             hwloop_i,
   input  logic [LVL_W-1:0] level_i,
   input  ctrl_t            ctrl_i,
   output logic             cap_o
);
   logic armed;
   logic lvl_ok;
   logic hipri;

   assign armed  = ctrl_i.pwr && ctrl_i.en;
   assign hipri  = (level_i <= LVL_W'(HIPRI_MAX));
   assign lvl_ok = (level_i != LVL_W'(RESET_LVL)) && !(ctrl_i.ovx && hipri);
   assign cap_o  = valid_i && armed && !hwloop_i && lvl_ok;
endmodule

// File: rtl/brt_store.sv
module brt_store
   import brt_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter bit          COMPRESS_EN = 1'b1,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned PW = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [PC_W-1:0]   src_i,
   input  logic [PC_W-1:0]   dst_i,
   input  logic              ovx_i,
   input  logic              fold1_en_i,
   input  logic              fold2_en_i,
   input  logic              data_rd_i,
   output logic [PW-1:0]     count_o,
   output logic [WORD_W-1:0] half_o,
   output logic              exc_o
);
   logic [PW-1:0] top_q, bot_q;
   logic [PW-1:0] cnt, cnt_p, top_p, top_n, bot_n;
   logic          mid_q;
   logic          exc_q;
   pair_t         slot_q [DEPTH];

   logic [IW-1:0] new_idx, last_idx, ll_idx, cur_idx;
   pair_t         cur_e, last_e, ll_e;
   logic          pop, full_p, exc, hit1, hit2, fold1, fold2, wr;

   // Occupancy and the pop that a data-port read performs.
   assign cnt    = top_q - bot_q;
   assign pop    = data_rd_i && (cnt != '0) && mid_q;
   assign top_p  = top_q - PW'(pop);
   assign cnt_p  = cnt - PW'(pop);
   assign full_p = (cnt_p == PW'(DEPTH));

   assign new_idx  = top_p[IW-1:0];
   assign last_idx = new_idx - IW'(1);
   assign ll_idx   = new_idx - IW'(2);
   assign cur_idx  = top_q[IW-1:0] - IW'(1);
   assign cur_e    = slot_q[cur_idx];
   assign last_e   = slot_q[last_idx];
   assign ll_e     = slot_q[ll_idx];

   // Folding comparators, present only when the variant asks for them.
   generate
      if (COMPRESS_EN) begin : g_fold
         logic same1, same2;
         assign same1 = (last_e.src[PC_W-1:1] == src_i[PC_W-1:1]) &&
                        (last_e.dst[PC_W-1:1] == dst_i[PC_W-1:1]);
         assign same2 = (ll_e.src[PC_W-1:1] == src_i[PC_W-1:1]) &&
                        (ll_e.dst[PC_W-1:1] == dst_i[PC_W-1:1]);
         assign hit1  = fold1_en_i && (cnt_p != '0) && same1;
         assign hit2  = fold2_en_i && (cnt_p >= PW'(2)) && same2;
      end else begin : g_nofold
         logic unused_fold;
         assign unused_fold = fold1_en_i ^ fold2_en_i ^ ^ll_e ^ ^last_e;
         assign hit1 = 1'b0;
         assign hit2 = 1'b0;
      end
   endgenerate

   assign exc   = cap_i && full_p && ovx_i;
   assign fold1 = cap_i && !exc && hit1;
   assign fold2 = cap_i && !exc && !hit1 && hit2;
   assign wr    = cap_i && !exc && !hit1 && !hit2;
   assign top_n = top_p + PW'(wr);
   assign bot_n = bot_q + PW'(wr && full_p);

   always_ff @(posedge clk) begin
      for (int s = 0; s < DEPTH; s++) begin
         if (wr && (new_idx == IW'(s))) begin
            slot_q[s].src <= src_i;
            slot_q[s].dst <= dst_i;
         end else begin
            if (fold1 && (last_idx == IW'(s))) slot_q[s].dst[0] <= 1'b1;
            if (fold2 && (ll_idx == IW'(s)))   slot_q[s].src[0] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= '0;
         bot_q <= '0;
         mid_q <= 1'b0;
         exc_q <= 1'b0;
      end else begin
         top_q <= top_n;
         bot_q <= bot_n;
         exc_q <= exc;
         if (data_rd_i && (cnt != '0)) mid_q <= !mid_q;
      end
   end

   assign count_o = cnt;
   assign exc_o   = exc_q;
   assign half_o  = (cnt == '0) ? '0 : (mid_q ? cur_e.src : cur_e.dst);

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(DEPTH));
   assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !data_rd_i) |=> ($stable(top_q) && $stable(bot_q)));
   assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && mid_q && (cnt != '0) && !cap_i) |=> (cnt == $past(cnt) - PW'(1)));
   assert_wrap_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && full_p && !ovx_i) |=> (cnt == PW'(DEPTH)));
   assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && full_p && ovx_i) |=> (exc_o && (cnt == PW'(DEPTH))));
endmodule

// File: rtl/brt_csr.sv
module brt_csr
   import brt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 9,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned STAT_CAP = 16,
   parameter int unsigned CTRL_OFS = 'h000,
   parameter int unsigned STAT_OFS = 'h004,
   parameter int unsigned DATA_OFS = 'h100,
   localparam int unsigned PW = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CTRL_W-1:0] wbits_i,
   input  logic [PW-1:0]     count_i,
   input  logic [WORD_W-1:0] half_i,
   output logic [WORD_W-1:0] rdata_o,
   output ctrl_t             ctrl_o,
   output logic              data_rd_o
);
   ctrl_t             ctrl_q;
   logic              sel_ctrl, sel_stat, sel_data;
   logic [WORD_W-1:0] stat_val;

   assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
   assign sel_stat = (addr_i == ADDR_W'(STAT_OFS));
   assign sel_data = (addr_i == ADDR_W'(DATA_OFS));

   // Count reported to software, clamped only when the store can exceed it.
   generate
      if (STAT_CAP >= DEPTH) begin : g_noclamp
         assign stat_val = WORD_W'(count_i);
      end else begin : g_clamp
         assign stat_val = (count_i > PW'(STAT_CAP)) ? WORD_W'(STAT_CAP) : WORD_W'(count_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_i && sel_ctrl) ctrl_q <= ctrl_t'(wbits_i);
   end

   always_comb begin
      rdata_o = '0;
      if (sel_ctrl)      rdata_o = WORD_W'(ctrl_q);
      else if (sel_stat) rdata_o = stat_val;
      else if (sel_data) rdata_o = half_i;
   end

   assign ctrl_o    = ctrl_q;
   assign data_rd_o = rd_i && sel_data;

   assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && sel_ctrl) |=> $stable(ctrl_q));
   assert_stat_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_stat) |-> (rdata_o <= WORD_W'(STAT_CAP)));
endmodule

// File: rtl/branch_trace_buffer.sv
module branch_trace_buffer
   import brt_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned STAT_CAP    = 16,
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned LVL_W       = 4,
   parameter int unsigned RESET_LVL   = 1,
   parameter int unsigned HIPRI_MAX   = 3,
   parameter bit          COMPRESS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tr_valid,
   input  logic [31:0]       tr_src,
   input  logic [31:0]       tr_dst,
   input  logic              tr_hwloop,
   input  logic [LVL_W-1:0]  tr_level,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ovf_exc
);
   localparam int unsigned PW = $clog2(DEPTH) + 1;

   generate
      if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 4");
      end
      if (STAT_CAP < 1) begin : g_bad_cap
         $error("STAT_CAP must be at least 1");
      end
      if ((1 << ADDR_W) <= 'h100) begin : g_bad_addr
         $error("ADDR_W too narrow for the data port offset");
      end
      if ((RESET_LVL >= (1 << LVL_W)) || (HIPRI_MAX >= (1 << LVL_W))) begin : g_bad_lvl
         $error("level parameters exceed LVL_W");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              cap;
   logic              data_rd;
   logic [PW-1:0]     count;
   logic [WORD_W-1:0] half;
   logic              unused_wbits;

   assign unused_wbits = ^reg_wdata[31:CTRL_W];

   brt_csr #(
      .ADDR_W  (ADDR_W),
      .DEPTH   (DEPTH),
      .STAT_CAP(STAT_CAP)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_i     (reg_rd),
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .wbits_i  (reg_wdata[CTRL_W-1:0]),
      .count_i  (count),
      .half_i   (half),
      .rdata_o  (reg_rdata),
      .ctrl_o   (ctrl),
      .data_rd_o(data_rd)
   );

   brt_gate #(
      .LVL_W    (LVL_W),
      .RESET_LVL(RESET_LVL),
      .HIPRI_MAX(HIPRI_MAX)
   ) u_gate (
      .valid_i (tr_valid),
      .hwloop_i(tr_hwloop),
      .level_i (tr_level),
      .ctrl_i  (ctrl),
      .cap_o   (cap)
   );

   brt_store #(
      .DEPTH      (DEPTH),
      .COMPRESS_EN(COMPRESS_EN)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (cap),
      .src_i     (tr_src),
      .dst_i     (tr_dst),
      .ovx_i     (ctrl.ovx),
      .fold1_en_i(ctrl.fold1),
      .fold2_en_i(ctrl.fold2),
      .data_rd_i (data_rd),
      .count_o   (count),
      .half_o    (half),
      .exc_o     (ovf_exc)
   );

   assert_exc_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_exc |-> ($past(tr_level) > LVL_W'(HIPRI_MAX)));
endmodule

// File: tb/sim_branch_trace_buffer.sv
`timescale 1ns/1ps
module sim_branch_trace_buffer;
   localparam int DEPTH = 16;
   localparam logic [8:0] A_CTRL = 9'h000;
   localparam logic [8:0] A_STAT = 9'h004;
   localparam logic [8:0] A_DATA = 9'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tr_valid = 1'b0;
   logic [31:0] tr_src = '0;
   logic [31:0] tr_dst = '0;
   logic        tr_hwloop = 1'b0;
   logic [3:0]  tr_level = 4'd6;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ovf_exc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference model state.
   logic [63:0] mq[$];
   bit          mmid = 1'b0;
   logic [4:0]  mctrl = '0;

   // Scoreboard queues.
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   branch_trace_buffer u0 (
      .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_src(tr_src),
      .tr_dst(tr_dst), .tr_hwloop(tr_hwloop), .tr_level(tr_level),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_exc(ovf_exc)
   );

   function automatic void chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endfunction

   function automatic bit same(input logic [63:0] e, input logic [31:0] s, input logic [31:0] d);
      return (e[63:33] == s[31:1]) && (e[31:1] == d[31:1]);
   endfunction

   function automatic logic [31:0] m_read();
      logic [31:0] v;
      if (mq.size() == 0) return '0;
      if (mmid) begin
         v = mq[mq.size()-1][63:32];
         void'(mq.pop_back());
      end else begin
         v = mq[mq.size()-1][31:0];
      end
      mmid = !mmid;
      return v;
   endfunction

   function automatic bit m_cap(input logic [31:0] s, input logic [31:0] d,
                                input bit hw, input int lvl);
      int n = mq.size();
      logic [63:0] t;
      if (!(mctrl[0] && mctrl[1])) return 1'b0;
      if (hw) return 1'b0;
      if (lvl == 1) return 1'b0;
      if (lvl <= 3 && mctrl[2]) return 1'b0;
      if (n == DEPTH && mctrl[2]) return 1'b1;
      if (n >= 1 && mctrl[3] && same(mq[n-1], s, d)) begin
         t = mq[n-1]; t[0] = 1'b1; mq[n-1] = t; return 1'b0;
      end
      if (n >= 2 && mctrl[4] && same(mq[n-2], s, d)) begin
         t = mq[n-2]; t[32] = 1'b1; mq[n-2] = t; return 1'b0;
      end
      if (n == DEPTH) void'(mq.pop_front());
      mq.push_back({s, d});
      return 1'b0;
   endfunction

   task automatic do_read(input logic [8:0] a, input string tag);
      logic [31:0] e;
      @(posedge clk); #1;
      if (a == A_DATA)      e = m_read();
      else if (a == A_STAT) e = (mq.size() > 16) ? 32'd16 : 32'(mq.size());
      else if (a == A_CTRL) e = {27'b0, mctrl};
      else                  e = '0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic do_write(input logic [8:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      if (a == A_CTRL) mctrl = d[4:0];
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic do_cap(input logic [31:0] s, input logic [31:0] d, input bit hw,
                         input int lvl, input string tag);
      bit x;
      @(posedge clk); #1;
      x = m_cap(s, d, hw, lvl);
      tr_valid = 1'b1; tr_src = s; tr_dst = d; tr_hwloop = hw; tr_level = 4'(lvl);
      @(posedge clk); #1;
      tr_valid = 1'b0; tr_hwloop = 1'b0;
      chk({31'b0, ovf_exc}, {31'b0, x}, {tag, " R8 exception flag"});
   endtask

   task automatic do_both(input logic [31:0] s, input logic [31:0] d, input int lvl, input string tag);
      logic [31:0] e;
      bit x;
      @(posedge clk); #1;
      e = m_read();
      x = m_cap(s, d, 1'b0, lvl);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = A_DATA;
      tr_valid = 1'b1; tr_src = s; tr_dst = d; tr_level = 4'(lvl);
      @(posedge clk); #1;
      reg_rd = 1'b0; tr_valid = 1'b0;
      chk({31'b0, ovf_exc}, {31'b0, x}, {tag, " exception flag"});
   endtask

   task automatic drain(input string tag);
      while (mq.size() != 0) do_read(A_DATA, tag);
      do_read(A_DATA, {tag, " empty"});
   endtask

   // Monitor: compare every read against the scoreboard.
   always @(negedge clk) begin : mon
      logic [31:0] e;
      string t;
      if (rst_n && reg_rd && exp_q.size() != 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(reg_rdata, e, t);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      do_read(A_CTRL, "R1 ctrl");
      do_read(A_STAT, "R1 count");
      do_read(A_DATA, "R1 data");
      chk({31'b0, ovf_exc}, 32'd0, "R1 exception low");

      // R2 power/enable gating
      do_cap(32'h100, 32'h200, 1'b0, 6, "R2 off");
      do_read(A_STAT, "R2 count with control 0");
      do_write(A_CTRL, 32'h1);
      do_cap(32'h100, 32'h200, 1'b0, 6, "R2 power only");
      do_read(A_STAT, "R2 count power only");
      do_write(A_CTRL, 32'h3);
      do_cap(32'h100, 32'h200, 1'b0, 6, "R2 on");
      do_read(A_STAT, "R2 count armed");

      // R3 hardware loop, R4 level rules
      do_cap(32'h300, 32'h400, 1'b1, 6, "R3");
      do_read(A_STAT, "R3 count after hwloop");
      do_cap(32'h300, 32'h400, 1'b0, 1, "R4 reset level");
      do_read(A_STAT, "R4 count reset level");
      do_write(A_CTRL, 32'h7);
      do_cap(32'h300, 32'h400, 1'b0, 2, "R4 level 2 ovx");
      do_cap(32'h300, 32'h400, 1'b0, 0, "R4 level 0 ovx");
      do_read(A_STAT, "R4 count high levels with ovx");
      do_write(A_CTRL, 32'h3);
      do_cap(32'h500, 32'h600, 1'b0, 2, "R4 level 2 no ovx");
      do_read(A_STAT, "R4 count level 2 stored");

      // R5 newest first, two halves, empty returns 0
      drain("R5 readout");
      do_read(A_STAT, "R5 count after drain");
      do_read(A_DATA, "R5 empty read");
      do_cap(32'h700, 32'h800, 1'b0, 6, "R5 after empty");
      do_read(A_DATA, "R5 first half after empty read");
      do_read(A_DATA, "R5 second half");

      // R11 control width and ignored writes
      do_write(A_CTRL, 32'hFFFF_FFE3);
      do_read(A_CTRL, "R11 ctrl readback");
      do_cap(32'h900, 32'hA00, 1'b0, 6, "R11 setup");
      do_write(A_STAT, 32'hFFFF_FFFF);
      do_write(A_DATA, 32'hFFFF_FFFF);
      do_read(A_CTRL, "R11 ctrl after other writes");
      do_read(A_STAT, "R11 count after ignored writes");
      do_read(A_DATA, "R11 phase after ignored writes");
      do_read(A_DATA, "R11 second half");

      // R9 one-level folding
      do_write(A_CTRL, 32'h0B);
      do_cap(32'h1000, 32'h2000, 1'b0, 6, "R9 first");
      do_cap(32'h1001, 32'h2000, 1'b0, 6, "R9 repeat");
      do_read(A_STAT, "R9 count");
      drain("R9 marker");

      // R10 two-level folding and priority
      do_write(A_CTRL, 32'h13);
      do_cap(32'h1000, 32'h2000, 1'b0, 6, "R10 a");
      do_cap(32'h3000, 32'h4000, 1'b0, 6, "R10 b");
      do_cap(32'h1000, 32'h2001, 1'b0, 6, "R10 a again");
      do_read(A_STAT, "R10 count");
      drain("R10 marker");
      do_write(A_CTRL, 32'h03);
      do_cap(32'h5000, 32'h6000, 1'b0, 6, "R10 g");
      do_cap(32'h5000, 32'h6000, 1'b0, 6, "R10 g dup");
      do_write(A_CTRL, 32'h1B);
      do_cap(32'h5000, 32'h6000, 1'b0, 6, "R10 both match");
      do_read(A_STAT, "R10 priority count");
      drain("R10 priority");

      // R7 overwrite oldest
      do_write(A_CTRL, 32'h03);
      for (int i = 0; i < 18; i++)
         do_cap(32'h1_0000 + 32'(i * 16), 32'h8_0000 + 32'(i * 16), 1'b0, 6, "R7 fill");
      do_read(A_STAT, "R7 count full");
      drain("R7 wrap");

      // R8 exception on full
      do_write(A_CTRL, 32'h07);
      for (int i = 0; i < 16; i++)
         do_cap(32'h2_0000 + 32'(i * 16), 32'h9_0000 + 32'(i * 16), 1'b0, 6, "R8 fill");
      do_cap(32'h7777_0000, 32'h7777_1000, 1'b0, 6, "R8 refused");
      @(posedge clk); #1;
      chk({31'b0, ovf_exc}, 32'd0, "R8 pulse one cycle");
      do_read(A_STAT, "R8 count still full");

      // R12 pop then capture in one cycle
      do_read(A_DATA, "R12 newest dst");
      do_both(32'h6666_0000, 32'h6666_1000, 6, "R12 pop with capture");
      do_read(A_STAT, "R12 count");
      drain("R12 readout");

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule